// File: doc/BRIEF.md
# Dual-Core Cluster Power State Controller

This controller moves each core of a two-core cluster between running and four low-power modes. It also switches the shared, inclusive L2 cache between fully on and fully off, and gates the L2 clock. Software or a higher-level power manager posts a target mode for a core as a one-cycle request. The controller sequences the core's clock enable, logic power, register retention, cache retention and reset outputs through a fixed order of one-cycle steps. It pulses an acknowledge for one cycle when the target mode is reached.

Both cores share one clock. The controller only adjusts power and retention per core, never the clock frequency. The L2 is powered down when its off request is held and both cores sit idle in a mode where their caches are already unpowered. Before power-down, a flush is handed to an external agent through a request/done handshake. A core that leaves a low-power mode while the L2 is not on waits until the L2 has been powered back and has settled.

Top module: `pwr_cluster_ctrl`

## Requirements
- R1: After reset every core is running: clock enable and logic power high, both retention outputs low, reset low, no acknowledge. The L2 is powered with its clock enabled, and no flush is requested.
- R2: Each core has a one-deep pending slot, and a newer request overwrites an older one. The request is serviced once that core's sequencer is idle. A one-cycle acknowledge marks arrival at the target. A request for the mode already held is acknowledged with no output change.
- R3: Light sleep (mode code 1) only drops the core clock enable. Logic power stays high and neither retention output is set.
- R4: Voltage retention (mode code 2) holds the clock off, sets both register and cache retention, and removes logic power.
- R5: Register retention (mode code 3) holds the clock off, sets register retention, clears cache retention and removes logic power.
- R6: Collapse (mode code 4, and codes 5 to 7 are read as collapse) leaves the clock, logic power, both retention outputs and reset all low.
- R7: Entry into a mode deeper than light sleep runs three steps on consecutive edges: clock off, retention set, logic power off. Exit runs logic power on, retention cleared, clock on. Mode code 0 is running.
- R8: On exit from collapse, reset rises with logic power. It falls with the clock enable, so it stays high for rst_hold + 3 cycles.
- R9: A change from one low-power mode to another passes through running (full exit, then entry) and gives a single acknowledge.
- R10: The L2 powers off only while l2_off_req is high and both cores are idle in register retention or collapse with nothing pending. flush_req is held until flush_done; the L2 clock is then stopped, and power is removed one cycle later.
- R11: While the L2 is on, l2_clk_en equals the inverse of l2_gate_req from one cycle earlier, whatever the cores are doing.
- R12: The L2 is powered back when l2_off_req drops or a core must leave a low-power mode. Its clock returns L2_SETTLE + 1 cycles after power. A waiting core starts its exit only after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared cluster clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | NUM_CORES | One-cycle request strobe per core |
| core_mode | input | 3*NUM_CORES | Target mode per core, 3 bits each |
| rst_hold | input | CNT_W | Extra reset-hold count for collapse exit |
| l2_off_req | input | 1 | Level: L2 should be powered off when allowed |
| l2_gate_req | input | 1 | Level: gate the L2 clock while on |
| flush_done | input | 1 | External flush agent finished |
| core_ack | output | NUM_CORES | One-cycle target-reached pulse per core |
| core_clk_en | output | NUM_CORES | Core clock enable |
| core_logic_pwr | output | NUM_CORES | Core logic power enable |
| core_reg_ret | output | NUM_CORES | Register retention enable |
| core_cache_ret | output | NUM_CORES | L1 cache retention enable |
| core_rst | output | NUM_CORES | Core reset during collapse exit |
| l2_pwr | output | 1 | L2 power enable |
| l2_clk_en | output | 1 | L2 clock enable |
| flush_req | output | 1 | L2 flush request to external agent |

## Verification
The hardest situation to reach is a core leaving a low-power mode while the L2 is off or in the middle of powering down. This needs both cores parked in a cache-less mode, the off request held, and a flush completed first. The bench steers the two cores into register retention and collapse, raises the off request, and answers the flush. Only then does it wake each core, so the wait-for-L2 path and the collapse reset window are both exercised. A random phase then interleaves requests, off-request changes and clock-gate toggles so that wake-ups also land during flush and settle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        M_RUN  = 3'd0,
        M_LSLP = 3'd1,
        M_VRET = 3'd2,
        M_RRET = 3'd3,
        M_COLL = 3'd4
    } pmode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_L2WAIT,
        S_X_PWR,
        S_X_RET,
        S_X_RST,
        S_X_CLK,
        S_E_CLK,
        S_E_RET,
        S_E_PWR,
        S_ACK
    } cseq_e;

    typedef enum logic [2:0] {
        L_ON,
        L_FLUSH,
        L_GATE,
        L_OFF,
        L_SETTLE
    } l2st_e;

    function automatic pmode_e norm_mode(logic [2:0] m);
        return (m > 3'd4) ? M_COLL : pmode_e'(m);
    endfunction

    function automatic logic is_deep(pmode_e m);
        return (m == M_RRET) || (m == M_COLL);
    endfunction

endpackage

// File: rtl/pcc_core_seq.sv
module pcc_core_seq
    import pcc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] rst_hold,
    input  logic             l2_ready,
    output logic             ack,
    output logic             clk_en,
    output logic             logic_pwr,
    output logic             reg_ret,
    output logic             cache_ret,
    output logic             core_rst,
    output logic             deep_idle,
    output logic             l2_wait
);

    typedef struct packed {
        cseq_e            st;
        pmode_e           cur;
        pmode_e           tgt;
        pmode_e           pend_m;
        logic             pend_v;
        logic [CNT_W-1:0] cnt;
        logic             clk_en;
        logic             pwr;
        logic             rret;
        logic             cret;
        logic             rst;
    } seq_t;

    seq_t seq_q, seq_d;

    function automatic cseq_e first_exit(pmode_e m);
        return (m == M_LSLP) ? S_X_CLK : S_X_PWR;
    endfunction

    always_comb begin
        seq_d = seq_q;

        // pending slot: newest request wins, cleared when taken
        if (req) begin
            seq_d.pend_v = 1'b1;
            seq_d.pend_m = norm_mode(mode);
        end else if (seq_q.st == S_IDLE && seq_q.pend_v) begin
            seq_d.pend_v = 1'b0;
        end

        unique case (seq_q.st)
            S_IDLE: begin
                if (seq_q.pend_v) begin
                    seq_d.tgt = seq_q.pend_m;
                    if (seq_q.pend_m == seq_q.cur)
                        seq_d.st = S_ACK;
                    else if (seq_q.cur != M_RUN)
                        seq_d.st = l2_ready ? first_exit(seq_q.cur) : S_L2WAIT;
                    else
                        seq_d.st = S_E_CLK;
                end
            end
            S_L2WAIT: begin
                if (l2_ready)
                    seq_d.st = first_exit(seq_q.cur);
            end
            S_X_PWR: begin
                seq_d.pwr = 1'b1;
                seq_d.rst = (seq_q.cur == M_COLL);
                seq_d.cnt = rst_hold;
                seq_d.st  = S_X_RET;
            end
            S_X_RET: begin
                seq_d.rret = 1'b0;
                seq_d.cret = 1'b0;
                seq_d.st   = (seq_q.cur == M_COLL) ? S_X_RST : S_X_CLK;
            end
            S_X_RST: begin
                if (seq_q.cnt == '0)
                    seq_d.st = S_X_CLK;
                else
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
            S_X_CLK: begin
                seq_d.clk_en = 1'b1;
                seq_d.rst    = 1'b0;
                seq_d.cur    = M_RUN;
                seq_d.st     = (seq_q.tgt == M_RUN) ? S_ACK : S_E_CLK;
            end
            S_E_CLK: begin
                seq_d.clk_en = 1'b0;
                if (seq_q.tgt == M_LSLP) begin
                    seq_d.cur = M_LSLP;
                    seq_d.st  = S_ACK;
                end else begin
                    seq_d.st = S_E_RET;
                end
            end
            S_E_RET: begin
                seq_d.rret = (seq_q.tgt == M_VRET) || (seq_q.tgt == M_RRET);
                seq_d.cret = (seq_q.tgt == M_VRET);
                seq_d.st   = S_E_PWR;
            end
            S_E_PWR: begin
                seq_d.pwr = 1'b0;
                seq_d.cur = seq_q.tgt;
                seq_d.st  = S_ACK;
            end
            S_ACK:   seq_d.st = S_IDLE;
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, cur: M_RUN, tgt: M_RUN, pend_m: M_RUN,
                       pend_v: 1'b0, cnt: '0, clk_en: 1'b1, pwr: 1'b1,
                       rret: 1'b0, cret: 1'b0, rst: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ack       = (seq_q.st == S_ACK);
    assign clk_en    = seq_q.clk_en;
    assign logic_pwr = seq_q.pwr;
    assign reg_ret   = seq_q.rret;
    assign cache_ret = seq_q.cret;
    assign core_rst  = seq_q.rst;
    assign deep_idle = (seq_q.st == S_IDLE) && !seq_q.pend_v && is_deep(seq_q.cur);
    assign l2_wait   = (seq_q.st == S_L2WAIT);

endmodule

// File: rtl/pcc_l2_ctrl.sv
module pcc_l2_ctrl
    import pcc_pkg::*;
#(
    parameter int L2_SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_req,
    input  logic gate_req,
    input  logic flush_done,
    input  logic all_deep,
    input  logic any_wait,
    output logic l2_pwr,
    output logic l2_clk_en,
    output logic flush_req,
    output logic l2_ready
);

    localparam int SW = $clog2(L2_SETTLE + 1);

    typedef struct packed {
        l2st_e         st;
        logic          pwr;
        logic          clk;
        logic          flush;
        logic [SW-1:0] cnt;
    } l2_t;

    l2_t l2_q, l2_d;

    always_comb begin
        l2_d = l2_q;
        unique case (l2_q.st)
            L_ON: begin
                l2_d.clk = !gate_req;
                if (off_req && all_deep) begin
                    l2_d.flush = 1'b1;
                    l2_d.st    = L_FLUSH;
                end
            end
            L_FLUSH: begin
                if (flush_done) begin
                    l2_d.flush = 1'b0;
                    l2_d.clk   = 1'b0;
                    l2_d.st    = L_GATE;
                end
            end
            L_GATE: begin
                l2_d.pwr = 1'b0;
                l2_d.st  = L_OFF;
            end
            L_OFF: begin
                if (!off_req || any_wait) begin
                    l2_d.pwr = 1'b1;
                    l2_d.cnt = SW'(L2_SETTLE);
                    l2_d.st  = L_SETTLE;
                end
            end
            L_SETTLE: begin
                if (l2_q.cnt == '0) begin
                    l2_d.clk = !gate_req;
                    l2_d.st  = L_ON;
                end else begin
                    l2_d.cnt = l2_q.cnt - SW'(1);
                end
            end
            default: l2_d.st = L_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            l2_q <= '{st: L_ON, pwr: 1'b1, clk: 1'b1, flush: 1'b0, cnt: '0};
        else
            l2_q <= l2_d;
    end

    assign l2_pwr    = l2_q.pwr;
    assign l2_clk_en = l2_q.clk;
    assign flush_req = l2_q.flush;
    assign l2_ready  = (l2_q.st == L_ON);

endmodule

// File: rtl/pwr_cluster_ctrl.sv
module pwr_cluster_ctrl
    import pcc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int CNT_W     = 8,
    parameter int L2_SETTLE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CORES-1:0]   core_req,
    input  logic [3*NUM_CORES-1:0] core_mode,
    input  logic [CNT_W-1:0]       rst_hold,
    input  logic                   l2_off_req,
    input  logic                   l2_gate_req,
    input  logic                   flush_done,
    output logic [NUM_CORES-1:0]   core_ack,
    output logic [NUM_CORES-1:0]   core_clk_en,
    output logic [NUM_CORES-1:0]   core_logic_pwr,
    output logic [NUM_CORES-1:0]   core_reg_ret,
    output logic [NUM_CORES-1:0]   core_cache_ret,
    output logic [NUM_CORES-1:0]   core_rst,
    output logic                   l2_pwr,
    output logic                   l2_clk_en,
    output logic                   flush_req
);

    logic [NUM_CORES-1:0] deep_idle;
    logic [NUM_CORES-1:0] l2_wait;
    logic                 l2_ready;

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
        pcc_core_seq #(.CNT_W(CNT_W)) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (core_req[gi]),
            .mode      (core_mode[3*gi +: 3]),
            .rst_hold  (rst_hold),
            .l2_ready  (l2_ready),
            .ack       (core_ack[gi]),
            .clk_en    (core_clk_en[gi]),
            .logic_pwr (core_logic_pwr[gi]),
            .reg_ret   (core_reg_ret[gi]),
            .cache_ret (core_cache_ret[gi]),
            .core_rst  (core_rst[gi]),
            .deep_idle (deep_idle[gi]),
            .l2_wait   (l2_wait[gi])
        );
    end

    pcc_l2_ctrl #(.L2_SETTLE(L2_SETTLE)) u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_req    (l2_off_req),
        .gate_req   (l2_gate_req),
        .flush_done (flush_done),
        .all_deep   (&deep_idle),
        .any_wait   (|l2_wait),
        .l2_pwr     (l2_pwr),
        .l2_clk_en  (l2_clk_en),
        .flush_req  (flush_req),
        .l2_ready   (l2_ready)
    );

endmodule

// File: rtl/pwr_cluster_ctrl_sva.sv
module pwr_cluster_ctrl_sva #(
    parameter int NUM_CORES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] core_ack,
    input logic [NUM_CORES-1:0] core_clk_en,
    input logic [NUM_CORES-1:0] core_logic_pwr,
    input logic [NUM_CORES-1:0] core_reg_ret,
    input logic [NUM_CORES-1:0] core_cache_ret,
    input logic [NUM_CORES-1:0] core_rst,
    input logic                 l2_pwr,
    input logic                 l2_clk_en,
    input logic                 flush_req,
    input logic                 flush_done
);

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_chk
        AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            core_ack[gi] |=> !core_ack[gi]); // R2
        AST_NOPWR_NOCLK: assert property (@(posedge clk) disable iff (!rst_n)
            !core_logic_pwr[gi] |-> !core_clk_en[gi]); // R7
        AST_PWR_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_logic_pwr[gi]) |-> !$past(core_clk_en[gi])); // R7
        AST_CLK_LAST_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_clk_en[gi]) |-> (core_logic_pwr[gi] && !core_reg_ret[gi] && !core_cache_ret[gi])); // R7
        AST_RST_POWERED_NOCLK: assert property (@(posedge clk) disable iff (!rst_n)
            core_rst[gi] |-> (core_logic_pwr[gi] && !core_clk_en[gi])); // R8
        AST_CACHE_NEEDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
            core_cache_ret[gi] |-> core_reg_ret[gi]); // R4
    end

    AST_L2_OFF_CORES_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !l2_pwr |-> (core_logic_pwr == '0 && core_cache_ret == '0)); // R10
    AST_L2_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        l2_clk_en |-> l2_pwr); // R11
    AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req); // R10
    AST_L2_OFF_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l2_pwr) |-> !$past(l2_clk_en)); // R10

endmodule

bind pwr_cluster_ctrl pwr_cluster_ctrl_sva #(.NUM_CORES(NUM_CORES)) u_sva (.*);

// File: tb/pwr_cluster_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_cluster_ctrl_tb;

    localparam int NC = 2;
    localparam int CW = 8;
    localparam int SETTLE = 4;

    localparam int OP_WAITL2 = 0, OP_XPWR = 1, OP_XRET = 2, OP_RSTW = 3,
                   OP_XCLK = 4, OP_EGATE = 5, OP_ERET = 6, OP_EPWR = 7, OP_IDLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]   core_req = '0;
    logic [3*NC-1:0] core_mode = '0;
    logic [CW-1:0]   rst_hold = 8'd5;
    logic l2_off_req = 1'b0, l2_gate_req = 1'b0, flush_done = 1'b0;
    logic [NC-1:0] core_ack, core_clk_en, core_logic_pwr, core_reg_ret, core_cache_ret, core_rst;
    logic l2_pwr, l2_clk_en, flush_req;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_cluster_ctrl #(.NUM_CORES(NC), .CNT_W(CW), .L2_SETTLE(SETTLE)) u_dut (.*);

    // ---------------- reference model ----------------
    int m_cur[NC], m_tgt[NC], m_busy[NC], m_pv[NC], m_pm[NC];
    int m_clk[NC], m_pwr[NC], m_rr[NC], m_cr[NC], m_rst[NC], m_ack[NC];
    int mq[NC][$];
    int ml_st, ml_pwr, ml_clk, ml_fl, ml_cnt;

    function automatic int nmode(int m);
        return (m > 4) ? 4 : m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_cur[c] = 0; m_tgt[c] = 0; m_busy[c] = 0; m_pv[c] = 0; m_pm[c] = 0;
                m_clk[c] = 1; m_pwr[c] = 1; m_rr[c] = 0; m_cr[c] = 0; m_rst[c] = 0; m_ack[c] = 0;
                mq[c].delete();
            end
            ml_st = 0; ml_pwr = 1; ml_clk = 1; ml_fl = 0; ml_cnt = 0;
        end else begin
            int ready_o, alld, anyw, st_n;
            ready_o = (ml_st == 0);
            alld = 1; anyw = 0;
            for (int c = 0; c < NC; c++) begin
                if (m_busy[c] || m_pv[c] || !(m_cur[c] == 3 || m_cur[c] == 4)) alld = 0;
                if (m_busy[c] && mq[c][0] == OP_WAITL2) anyw = 1;
            end
            for (int c = 0; c < NC; c++) begin
                int started;
                started = 0;
                m_ack[c] = 0;
                if (m_busy[c]) begin
                    int op;
                    op = mq[c][0];
                    if (!(op == OP_WAITL2 && !ready_o)) begin
                        void'(mq[c].pop_front());
                        case (op)
                            OP_XPWR:  begin m_pwr[c] = 1; m_rst[c] = (m_cur[c] == 4); end
                            OP_XRET:  begin m_rr[c] = 0; m_cr[c] = 0; end
                            OP_XCLK:  begin m_clk[c] = 1; m_rst[c] = 0; m_cur[c] = 0; end
                            OP_EGATE: begin m_clk[c] = 0; if (m_tgt[c] == 1) m_cur[c] = 1; end
                            OP_ERET:  begin m_rr[c] = (m_tgt[c] == 2 || m_tgt[c] == 3); m_cr[c] = (m_tgt[c] == 2); end
                            OP_EPWR:  begin m_pwr[c] = 0; m_cur[c] = m_tgt[c]; end
                            default: ;
                        endcase
                        if (op == OP_IDLE) m_busy[c] = 0;
                        else if (mq[c][0] == OP_IDLE) m_ack[c] = 1;
                    end
                end else if (m_pv[c]) begin
                    started = 1;
                    m_busy[c] = 1;
                    m_tgt[c] = m_pm[c];
                    if (m_pm[c] == m_cur[c]) begin
                        m_ack[c] = 1;
                    end else begin
                        if (m_cur[c] != 0) begin
                            if (!ready_o) mq[c].push_back(OP_WAITL2);
                            if (m_cur[c] == 1) mq[c].push_back(OP_XCLK);
                            else begin
                                mq[c].push_back(OP_XPWR);
                                mq[c].push_back(OP_XRET);
                                if (m_cur[c] == 4)
                                    for (int k = 0; k <= int'(rst_hold); k++) mq[c].push_back(OP_RSTW);
                                mq[c].push_back(OP_XCLK);
                            end
                        end
                        if (m_tgt[c] != 0) begin
                            mq[c].push_back(OP_EGATE);
                            if (m_tgt[c] != 1) begin
                                mq[c].push_back(OP_ERET);
                                mq[c].push_back(OP_EPWR);
                            end
                        end
                    end
                    mq[c].push_back(OP_IDLE);
                end
                if (core_req[c]) begin
                    m_pv[c] = 1; m_pm[c] = nmode(int'(core_mode[3*c +: 3]));
                end else if (started) begin
                    m_pv[c] = 0;
                end
            end
            st_n = ml_st;
            case (ml_st)
                0: begin ml_clk = !l2_gate_req; if (l2_off_req && alld) begin ml_fl = 1; st_n = 1; end end
                1: if (flush_done) begin ml_fl = 0; ml_clk = 0; st_n = 2; end
                2: begin ml_pwr = 0; st_n = 3; end
                3: if (!l2_off_req || anyw) begin ml_pwr = 1; ml_cnt = SETTLE; st_n = 4; end
                default: if (ml_cnt == 0) begin ml_clk = !l2_gate_req; st_n = 0; end else ml_cnt--;
            endcase
            ml_st = st_n;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string rq, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", rq, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NC; c++) begin
                chk("R7", $sformatf("clk_en[%0d]", c), int'(core_clk_en[c]), m_clk[c]);
                chk("R7", $sformatf("logic_pwr[%0d]", c), int'(core_logic_pwr[c]), m_pwr[c]);
                chk("R5", $sformatf("reg_ret[%0d]", c), int'(core_reg_ret[c]), m_rr[c]);
                chk("R4", $sformatf("cache_ret[%0d]", c), int'(core_cache_ret[c]), m_cr[c]);
                chk("R8", $sformatf("core_rst[%0d]", c), int'(core_rst[c]), m_rst[c]);
                chk("R2", $sformatf("ack[%0d]", c), int'(core_ack[c]), m_ack[c]);
            end
            chk("R10", "l2_pwr", int'(l2_pwr), ml_pwr);
            chk("R11", "l2_clk_en", int'(l2_clk_en), ml_clk);
            chk("R10", "flush_req", int'(flush_req), ml_fl);
        end
    end

    // external flush agent
    int fcnt = 0;
    always @(negedge clk) begin
        if (flush_done) flush_done <= 1'b0;
        else if (flush_req) begin
            if (fcnt == 2) begin flush_done <= 1'b1; fcnt = 0; end
            else fcnt++;
        end
    end

    task automatic req(int c, int m);
        @(negedge clk);
        core_req[c] = 1'b1;
        core_mode[3*c +: 3] = 3'(m);
        @(negedge clk);
        core_req[c] = 1'b0;
    endtask

    task automatic wait_ack(int c);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (core_ack[c]) break;
        end
    endtask

    task automatic steady(string rq, int c, int ce, int lp, int rr, int cr);
        chk(rq, "steady clk_en", int'(core_clk_en[c]), ce);
        chk(rq, "steady logic_pwr", int'(core_logic_pwr[c]), lp);
        chk(rq, "steady reg_ret", int'(core_reg_ret[c]), rr);
        chk(rq, "steady cache_ret", int'(core_cache_ret[c]), cr);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1 reset state
        for (int c = 0; c < NC; c++) begin
            steady("R1", c, 1, 1, 0, 0);
            chk("R1", "rst", int'(core_rst[c]), 0);
            chk("R1", "ack", int'(core_ack[c]), 0);
        end
        chk("R1", "l2_pwr", int'(l2_pwr), 1);
        chk("R1", "l2_clk_en", int'(l2_clk_en), 1);
        chk("R1", "flush_req", int'(flush_req), 0);
        rst_n = 1'b1;

        req(0, 1); wait_ack(0); @(negedge clk);
        steady("R3", 0, 0, 1, 0, 0);
        req(0, 0); wait_ack(0);

        req(1, 2); req(0, 3);
        repeat (20) @(negedge clk);
        steady("R4", 1, 0, 0, 1, 1);
        steady("R5", 0, 0, 0, 1, 0);

        // R2: second request arrives while first is being serviced
        n = 0;
        req(1, 0); req(1, 1);
        repeat (40) begin @(negedge clk); if (core_ack[1]) n++; end
        chk("R2", "acks for two queued requests", n, 2);
        steady("R2", 1, 0, 1, 0, 0);
        req(1, 1);
        n = 0;
        repeat (6) begin @(negedge clk); if (core_ack[1]) n++; end
        chk("R2", "ack for same-mode request", n, 1);

        // R9: light sleep to collapse through running
        n = 0;
        req(1, 7);
        repeat (40) begin @(negedge clk); if (core_ack[1]) n++; end
        chk("R9", "single ack low-to-low", n, 1);
        steady("R6", 1, 0, 0, 0, 0);
        chk("R6", "rst in collapse", int'(core_rst[1]), 0);

        // R10: L2 off
        l2_off_req = 1'b1;
        repeat (30) @(negedge clk);
        chk("R10", "l2 powered off", int'(l2_pwr), 0);

        // R12: wake core0 with L2 off
        n = 0;
        req(0, 0);
        for (int k = 0; k < 200 && !core_ack[0]; k++) begin
            @(negedge clk);
            if (l2_pwr && !l2_clk_en) n++;
        end
        chk("R12", "L2 settle cycles", n, SETTLE + 1);
        req(0, 3);
        repeat (40) @(negedge clk);
        chk("R10", "l2 off again", int'(l2_pwr), 0);

        // R8: collapse exit reset length
        n = 0;
        req(1, 0);
        for (int k = 0; k < 200 && !core_ack[1]; k++) begin
            @(negedge clk);
            if (core_rst[1]) n++;
        end
        chk("R8", "reset cycles", n, int'(rst_hold) + 3);

        // R11: gate while running
        l2_off_req = 1'b0;
        repeat (20) @(negedge clk);
        l2_gate_req = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R11", "gated l2 clock", int'(l2_clk_en), 0);
        l2_gate_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R11", "ungated l2 clock", int'(l2_clk_en), 1);

        // random phase
        rst_hold = 8'd2;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            for (int c = 0; c < NC; c++) begin
                core_req[c] = ($urandom_range(0, 9) == 0);
                core_mode[3*c +: 3] = 3'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 30) == 0) l2_off_req = ~l2_off_req;
            if ($urandom_range(0, 10) == 0) l2_gate_req = ~l2_gate_req;
        end
        core_req = '0;
        repeat (50) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule